// File: doc/BRIEF.md
# Configuration Register Entry Detector

This block is the device-side watcher of a pseudo-static memory. It decides when a host is programming the memory's configuration word and stores that word. It samples the asynchronous control pins and the 22-bit address bus with a local sampling clock. It treats an access as complete on the sample where chip select returns high.

There are two ways in. In the pin method, the dedicated strobe pin is driven low and a fully qualified write must follow within a window of sampling cycles. The address of that write becomes the new configuration word. If no such write arrives in time, the block raises its partial-refresh entry flag instead. In the software method, five ordinary reads in a row unlock the register. The first three reads go to the all-ones address, the fourth goes to 0x3FFEFF, and the address of the fifth is the new value.

Every stored word is normalised before it is kept. Reserved burst codes are replaced by the default code, and the reserved bit is cleared. The partial-refresh fields are brought out decoded.

Top module: `cfgreg_entry_detect`

## Requirements
- R1: After reset, cfg_word is 0x0000F0: burst field A7:A5 = 111, refresh-disable bit A4 = 1, size A1:A0 = 00 (full array), array select A3 = 0 (bottom). At the same time, upd_done and par_entry are 0.
- R2: The software method loads the register. It takes three reads at 0x3FFFFF, then one read at 0x3FFEFF, then a fifth read, with chip select high between reads. The fifth read's address, normalised, appears on cfg_word two sampling cycles after chip select rises at the end of that read.
- R3: A read whose address does not match its position in the sequence resets the count to zero, and that read is not itself counted. A sequence broken this way never loads the register.
- R4: A write (WE# low) completed while one to four reads have been counted resets the count to zero.
- R5: The state of ADV# during the reads has no effect on the software method.
- R6: In the pin method, MRS# is driven low first. A write is then completed with CS#, ADV#, UB#, LB# and WE# low and OE# high, within WINDOW sampling cycles of the MRS# fall being seen. The write's address, normalised, is loaded, and par_entry stays 0.
- R7: If no qualified write completes within WINDOW cycles of the MRS# fall, par_entry goes to 1 and cfg_word is unchanged. par_entry returns to 0 once MRS# is sampled high.
- R8: A write during the pin window that has any of UB#, LB# or ADV# high, or OE# low, does not load the register.
- R9: A burst code of 000, 001, 101 or 110 in A7:A5 is stored as 111. The codes 010, 011, 100 and 111 are stored as given.
- R10: Bit A12 is always stored as 0. All other bits outside A7:A5 and A12 are stored as given.
- R11: upd_done is high for exactly one cycle for each register load, and in the same cycle cfg_word takes the new value.
- R12: par_size equals stored bits A1:A0, par_top equals A3, par_en is the inverse of A4, and burst_code equals A7:A5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the detector |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address valid, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper byte enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| mrs_n | input | 1 | Register-set strobe pin, active low |
| addr | input | 22 | Address bus |
| cfg_word | output | 22 | Stored, normalised configuration word |
| burst_code | output | 3 | Stored burst-length code |
| par_size | output | 2 | Partial-refresh size code |
| par_top | output | 1 | Partial-refresh array select (1 = top) |
| par_en | output | 1 | Partial-refresh enabled |
| upd_done | output | 1 | One-cycle pulse on each register load |
| par_entry | output | 1 | Pin strobe timed out; refresh mode entered |

## Verification
Loads from both methods land two sampling edges after the sample that sees CS# high. The first edge registers the pins and the second writes the register. The driver therefore pushes the expected normalised word into the queue at the moment it releases chip select. A monitor working on the falling clock edge pops that entry on every upd_done pulse and compares it to cfg_word. A pulse with an empty queue, or an entry still in the queue at the end, counts as a miscompare. The par_entry timeout comes about WINDOW+3 cycles after the MRS# fall. The bench reads it only after waiting well past that point, then raises MRS# and looks again a few cycles later.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
  localparam int CFG_AW   = 22;
  localparam int BL_LSB   = 5;
  localparam int BL_W     = 3;
  localparam int RSV_BIT  = 12;
  localparam int PDIS_BIT = 4;
  localparam int PTOP_BIT = 3;
  localparam int PSZ_LSB  = 0;
  localparam int PSZ_W    = 2;
  localparam logic [BL_W-1:0] BL_DEFAULT = 3'b111;
  localparam logic [CFG_AW-1:0] CFG_RESET = 22'h0000F0;

  function automatic logic bl_is_valid(input logic [BL_W-1:0] c);
    case (c)
      3'b010, 3'b011, 3'b100, 3'b111: bl_is_valid = 1'b1;
      default:                        bl_is_valid = 1'b0;
    endcase
  endfunction

  function automatic logic [CFG_AW-1:0] cfg_normalize(input logic [CFG_AW-1:0] a);
    logic [CFG_AW-1:0] w;
    w = a;
    w[RSV_BIT] = 1'b0;
    if (!bl_is_valid(a[BL_LSB +: BL_W]))
      w[BL_LSB +: BL_W] = BL_DEFAULT;
    cfg_normalize = w;
  endfunction
endpackage

// File: rtl/cfgreg_pin_sampler.sv
module cfgreg_pin_sampler #(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          adv_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          ub_n,
  input  logic          lb_n,
  input  logic          mrs_n,
  input  logic [AW-1:0] addr,
  output logic          rd_end,
  output logic          wr_end,
  output logic          qual_wr_end,
  output logic          mrs_fall,
  output logic          mrs_high,
  output logic [AW-1:0] acc_addr
);
  typedef struct packed {
    logic          cs;
    logic          adv;
    logic          we;
    logic          oe;
    logic          ub;
    logic          lb;
    logic          mrs;
    logic [AW-1:0] a;
  } pins_t;

  pins_t cur, s_q, p_q;

  always_comb begin
    cur.cs  = cs_n;
    cur.adv = adv_n;
    cur.we  = we_n;
    cur.oe  = oe_n;
    cur.ub  = ub_n;
    cur.lb  = lb_n;
    cur.mrs = mrs_n;
    cur.a   = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= '{cs: 1'b1, adv: 1'b1, we: 1'b1, oe: 1'b1, ub: 1'b1, lb: 1'b1,
               mrs: 1'b1, a: '0};
      p_q <= '{cs: 1'b1, adv: 1'b1, we: 1'b1, oe: 1'b1, ub: 1'b1, lb: 1'b1,
               mrs: 1'b1, a: '0};
    end else begin
      s_q <= cur;
      p_q <= s_q;
    end
  end

  logic acc_end;
  assign acc_end     = !p_q.cs && s_q.cs;
  assign rd_end      = acc_end && !p_q.oe && p_q.we;
  assign wr_end      = acc_end && !p_q.we;
  assign qual_wr_end = wr_end && !p_q.adv && !p_q.ub && !p_q.lb && p_q.oe;
  assign mrs_fall    = p_q.mrs && !s_q.mrs;
  assign mrs_high    = s_q.mrs;
  assign acc_addr    = p_q.a;
endmodule

// File: rtl/cfgreg_sw_unlock.sv
module cfgreg_sw_unlock #(
  parameter int          AW       = 22,
  parameter int          N_READS  = 5,
  parameter logic [21:0] KEY_A    = 22'h3FFFFF,
  parameter logic [21:0] KEY_B    = 22'h3FFEFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_end,
  input  logic          wr_end,
  input  logic [AW-1:0] acc_addr,
  output logic          sw_load
);
  localparam int CW = $clog2(N_READS);
  localparam logic [CW-1:0] LAST = CW'(N_READS - 1);
  localparam logic [CW-1:0] KEYB_POS = CW'(N_READS - 2);

  logic [CW-1:0] cnt_q;
  logic          key_hit;

  function automatic logic key_match(input logic [CW-1:0] pos, input logic [AW-1:0] a);
    if (pos == KEYB_POS) key_match = (a == AW'(KEY_B));
    else                 key_match = (a == AW'(KEY_A));
  endfunction

  assign key_hit = key_match(cnt_q, acc_addr);
  assign sw_load = rd_end && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (sw_load) begin
      cnt_q <= '0;
    end else if (rd_end) begin
      cnt_q <= key_hit ? cnt_q + 1'b1 : '0;
    end else if (wr_end) begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/cfgreg_pin_entry.sv
module cfgreg_pin_entry #(
  parameter int WINDOW = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mrs_fall,
  input  logic mrs_high,
  input  logic qual_wr_end,
  output logic pin_load,
  output logic pin_armed,
  output logic par_entry
);
  localparam int TW = $clog2(WINDOW + 1);
  localparam logic [TW-1:0] LIMIT = TW'(WINDOW - 1);

  logic [TW-1:0] tmr_q;
  logic          armed_q;
  logic          par_q;
  logic          expire;

  assign pin_load  = armed_q && qual_wr_end;
  assign expire    = armed_q && !qual_wr_end && (tmr_q == LIMIT);
  assign pin_armed = armed_q;
  assign par_entry = par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      tmr_q   <= '0;
    end else if (mrs_fall) begin
      armed_q <= 1'b1;
      tmr_q   <= '0;
    end else if (pin_load || expire || mrs_high) begin
      armed_q <= 1'b0;
      tmr_q   <= '0;
    end else if (armed_q) begin
      tmr_q   <= tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        par_q <= 1'b0;
    else if (mrs_high) par_q <= 1'b0;
    else if (expire)   par_q <= 1'b1;
  end
endmodule

// File: rtl/cfgreg_store.sv
module cfgreg_store
  import cfgreg_pkg::*;
#(
  parameter int AW = CFG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_load,
  input  logic          pin_load,
  input  logic [AW-1:0] acc_addr,
  output logic [AW-1:0] cfg_word,
  output logic          upd_done
);
  logic [AW-1:0] cfg_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= AW'(CFG_RESET);
      done_q <= 1'b0;
    end else begin
      done_q <= sw_load || pin_load;
      if (sw_load || pin_load)
        cfg_q <= AW'(cfg_normalize(CFG_AW'(acc_addr)));
    end
  end

  assign cfg_word = cfg_q;
  assign upd_done = done_q;
endmodule

// File: rtl/cfgreg_entry_detect.sv
module cfgreg_entry_detect
  import cfgreg_pkg::*;
#(
  parameter int AW     = CFG_AW,
  parameter int WINDOW = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          adv_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          ub_n,
  input  logic          lb_n,
  input  logic          mrs_n,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] cfg_word,
  output logic [2:0]    burst_code,
  output logic [1:0]    par_size,
  output logic          par_top,
  output logic          par_en,
  output logic          upd_done,
  output logic          par_entry
);
  logic          rd_end, wr_end, qual_wr_end, mrs_fall, mrs_high;
  logic [AW-1:0] acc_addr;
  logic          sw_load, pin_load, pin_armed;

  cfgreg_pin_sampler #(.AW(AW)) u_smp (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n),
    .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n), .mrs_n(mrs_n), .addr(addr),
    .rd_end(rd_end), .wr_end(wr_end), .qual_wr_end(qual_wr_end),
    .mrs_fall(mrs_fall), .mrs_high(mrs_high), .acc_addr(acc_addr)
  );

  cfgreg_sw_unlock #(.AW(AW)) u_sw (
    .clk(clk), .rst_n(rst_n), .rd_end(rd_end), .wr_end(wr_end),
    .acc_addr(acc_addr), .sw_load(sw_load)
  );

  cfgreg_pin_entry #(.WINDOW(WINDOW)) u_pin (
    .clk(clk), .rst_n(rst_n), .mrs_fall(mrs_fall), .mrs_high(mrs_high),
    .qual_wr_end(qual_wr_end), .pin_load(pin_load), .pin_armed(pin_armed),
    .par_entry(par_entry)
  );

  cfgreg_store #(.AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .sw_load(sw_load), .pin_load(pin_load),
    .acc_addr(acc_addr), .cfg_word(cfg_word), .upd_done(upd_done)
  );

  assign burst_code = cfg_word[BL_LSB +: BL_W];
  assign par_size   = cfg_word[PSZ_LSB +: PSZ_W];
  assign par_top    = cfg_word[PTOP_BIT];
  assign par_en     = !cfg_word[PDIS_BIT];
endmodule

// File: rtl/cfgreg_entry_detect_chk.sv
module cfgreg_entry_detect_chk #(
  parameter int AW = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cfg_word,
  input logic          upd_done,
  input logic          par_entry,
  input logic          sw_load,
  input logic          pin_load,
  input logic          pin_armed
);
  // R11
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !upd_done);

  // R11
  cfg_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_word) |-> upd_done);

  // R2
  upd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> $past(sw_load || pin_load));

  // R7
  par_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_entry) |-> $stable(cfg_word) && $past(pin_armed));

  // R6
  pin_noload_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_load |=> !$rose(par_entry));

  // R10
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> !cfg_word[12]);
endmodule

bind cfgreg_entry_detect cfgreg_entry_detect_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .upd_done(upd_done),
  .par_entry(par_entry), .sw_load(sw_load), .pin_load(pin_load),
  .pin_armed(pin_armed)
);

// File: tb/cfgreg_entry_detect_tb.sv
`timescale 1ns/1ps
module cfgreg_entry_detect_tb;
  localparam int AW  = 22;
  localparam int WIN = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, adv_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic ub_n = 1'b1, lb_n = 1'b1, mrs_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] cfg_word;
  logic [2:0] burst_code;
  logic [1:0] par_size;
  logic par_top, par_en, upd_done, par_entry;

  int n_vec = 0;
  int n_bad = 0;
  int n_upd = 0;
  logic [AW-1:0] exp_q[$];
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  cfgreg_entry_detect #(.AW(AW), .WINDOW(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n),
    .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n), .mrs_n(mrs_n), .addr(addr),
    .cfg_word(cfg_word), .burst_code(burst_code), .par_size(par_size),
    .par_top(par_top), .par_en(par_en), .upd_done(upd_done),
    .par_entry(par_entry)
  );

  function automatic logic [AW-1:0] expect_word(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    r = a;
    r[12] = 1'b0;
    if (a[7:5] == 3'b000 || a[7:5] == 3'b001 || a[7:5] == 3'b101 || a[7:5] == 3'b110)
      r[7:5] = 3'b111;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic adv);
    addr = a; adv_n = adv; we_n = 1'b1; oe_n = 1'b0; cs_n = 1'b0;
    cyc(3);
    cs_n = 1'b1; oe_n = 1'b1; adv_n = 1'b1;
    cyc(3);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic ub, input logic lb,
                          input logic adv, input logic oe);
    addr = a; adv_n = adv; ub_n = ub; lb_n = lb; oe_n = oe; we_n = 1'b0; cs_n = 1'b0;
    cyc(3);
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; ub_n = 1'b1; lb_n = 1'b1; adv_n = 1'b1;
    cyc(3);
  endtask

  task automatic sw_seq(input logic [AW-1:0] v, input logic adv);
    do_read(22'h3FFFFF, adv);
    do_read(22'h3FFFFF, 1'b1);
    do_read(22'h3FFFFF, adv);
    do_read(22'h3FFEFF, 1'b1);
    addr = v; adv_n = adv; we_n = 1'b1; oe_n = 1'b0; cs_n = 1'b0;
    cyc(3);
    exp_q.push_back(expect_word(v));
    cs_n = 1'b1; oe_n = 1'b1; adv_n = 1'b1;
    cyc(4);
  endtask

  // Scoreboard monitor: R2 R6 R11
  always @(negedge clk) begin
    if (rst_n && !done && upd_done) begin
      n_upd++;
      if (exp_q.size() == 0) begin
        check("R3 unexpected load", {10'd0, cfg_word}, 32'hFFFFFFFF);
      end else begin
        logic [AW-1:0] e;
        e = exp_q.pop_front();
        check("R2/R6/R9/R10 loaded word", {10'd0, cfg_word}, {10'd0, e});
      end
      @(negedge clk);
      check("R11 pulse width", {31'd0, upd_done}, 32'd0);
    end
  end

  initial begin
    int wd;
    for (wd = 0; wd < 150000 && !done; wd++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int u0;
    cyc(3);
    // R1 reset state
    check("R1 cfg reset", {10'd0, cfg_word}, 32'h0000F0);
    check("R1 upd_done reset", {31'd0, upd_done}, 32'd0);
    check("R1 par_entry reset", {31'd0, par_entry}, 32'd0);
    rst_n = 1'b1;
    cyc(3);

    // R2 R9 R10 R12: software method, valid burst, A12 set
    sw_seq(22'h001052, 1'b1);
    check("R12 burst_code", {29'd0, burst_code}, 32'd2);
    check("R12 par_size", {30'd0, par_size}, 32'd2);
    check("R12 par_en", {31'd0, par_en}, 32'd0);
    check("R12 par_top", {31'd0, par_top}, 32'd0);

    // R5 R9: ADV# low during reads, reserved burst 000
    sw_seq(22'h10000B, 1'b0);
    check("R12 par_en on", {31'd0, par_en}, 32'd1);
    check("R12 par_top on", {31'd0, par_top}, 32'd1);
    check("R9 burst default", {29'd0, burst_code}, 32'd7);

    // R3: broken sequence must not load
    u0 = n_upd;
    do_read(22'h3FFFFF, 1'b1);
    do_read(22'h3FFFFF, 1'b1);
    do_read(22'h000123, 1'b1);
    do_read(22'h3FFFFF, 1'b1);
    do_read(22'h3FFEFF, 1'b1);
    do_read(22'h000055, 1'b1);
    cyc(4);
    check("R3 no load after mismatch", n_upd, u0);
    check("R3 cfg held", {10'd0, cfg_word}, {10'd0, expect_word(22'h10000B)});

    // R4: write during the count aborts
    do_read(22'h3FFFFF, 1'b1);
    do_read(22'h3FFFFF, 1'b1);
    do_write(22'h000000, 1'b0, 1'b0, 1'b0, 1'b1);
    do_read(22'h3FFFFF, 1'b1);
    do_read(22'h3FFEFF, 1'b1);
    do_read(22'h000077, 1'b1);
    cyc(4);
    check("R4 no load after write", n_upd, u0);
    // recovery with burst 110 reserved
    sw_seq(22'h0000C1, 1'b1);

    // R6: pin method with qualified write, reserved burst 101
    mrs_n = 1'b0;
    cyc(5);
    addr = 22'h2A0A6; adv_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; cs_n = 1'b0;
    cyc(3);
    exp_q.push_back(expect_word(22'h2A0A6));
    cs_n = 1'b1; we_n = 1'b1; ub_n = 1'b1; lb_n = 1'b1; adv_n = 1'b1;
    cyc(WIN + 10);
    check("R6 no par after good write", {31'd0, par_entry}, 32'd0);
    mrs_n = 1'b1;
    cyc(4);

    // R8 R7: unqualified write (UB# high) then timeout
    u0 = n_upd;
    mrs_n = 1'b0;
    cyc(5);
    do_write(22'h000044, 1'b1, 1'b0, 1'b0, 1'b1);
    cyc(WIN + 10);
    check("R8 no load on UB# high", n_upd, u0);
    check("R7 par_entry set", {31'd0, par_entry}, 32'd1);
    check("R7 cfg unchanged", {10'd0, cfg_word}, {10'd0, expect_word(22'h2A0A6)});
    mrs_n = 1'b1;
    cyc(4);
    check("R7 par_entry cleared", {31'd0, par_entry}, 32'd0);

    // R8: OE# low write rejected, plain timeout
    mrs_n = 1'b0;
    cyc(5);
    do_write(22'h000044, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(WIN + 10);
    check("R8 no load on OE# low", n_upd, u0);
    check("R7 par_entry set again", {31'd0, par_entry}, 32'd1);
    mrs_n = 1'b1;
    cyc(4);

    // R10: pin method with A12 set and valid burst 100
    mrs_n = 1'b0;
    cyc(3);
    addr = 22'h001089; adv_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; cs_n = 1'b0;
    cyc(3);
    exp_q.push_back(expect_word(22'h001089));
    cs_n = 1'b1; we_n = 1'b1; ub_n = 1'b1; lb_n = 1'b1; adv_n = 1'b1;
    cyc(6);
    mrs_n = 1'b1;
    cyc(4);
    check("R10 A12 stored low", {31'd0, cfg_word[12]}, 32'd0);
    check("R12 burst valid kept", {29'd0, burst_code}, 32'd4);

    check("R2 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule